// File: doc/BRIEF.md
# Keyed Bit-Plane Watermark Embedder and Extractor

This block sits on the coefficient stream that leaves a two-dimensional wavelet transform stage. Each coefficient arrives with a flag that marks it as part of the lowest-frequency (DC) subband. The block overwrites one bit of every flagged coefficient with the next bit of a watermark stream. All other coefficients pass through untouched. The bit position is taken from a window of one, two or four adjacent bit-planes. When the window is wider than one plane, a keyed 16-bit linear feedback shift register picks the plane for each coefficient.

In extract mode the same key logic runs over a received stream. For each DC coefficient the block reports the bit at the chosen plane, and no original image is needed. Comparing those bits with the expected mark shows whether the image was altered and where. Both modes share the key generator and the plane selection. Only the final data multiplexer differs, so an extractor given the same seed, window and frame start stays in step with the embedder.

Three streams use valid/ready handshakes: coefficients in, watermark bits in, and results out. A result is held unchanged while `m_ready` is low. The output stage is a single register, so a new coefficient is taken in the same cycle that the previous result leaves. `s_ready` depends on `s_is_dc`, on the mode and on `wm_valid`, because an embedded DC coefficient needs a watermark bit in the same cycle. The two handshakes then complete together. `wm_ready` is raised only for that case, so non-DC traffic and extract mode never consume watermark bits. With the output free and watermark bits available, one coefficient moves per clock.

Top module: `wm_bitplane_embed`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `m_valid` is 0.
- R2: A coefficient with `s_is_dc`=0 appears on `m_coef` unchanged one cycle after it is accepted, with `m_is_dc`=0 and `m_xbit`=0.
- R3: In embed mode (`cfg_extract`=0), an accepted DC coefficient leaves with exactly the selected bit replaced by `wm_bit`, and every other bit equal to the input. `m_xbit` carries the embedded bit.
- R4: The plane is `cfg_base` + offset. The window width is 1 for `cfg_span`=0, 2 for 1, and 4 for 2 or 3. The offset is the current key ANDed with (width-1), that is, its low bits.
- R5: Bit 15 (the sign) of a DC coefficient is never altered.
- R6: In extract mode (`cfg_extract`=1), every coefficient leaves unchanged. For a DC coefficient, `m_xbit` equals the input bit at the selected plane.
- R7: While `m_valid`=1 and `m_ready`=0, the outputs hold their values and no new coefficient is accepted.
- R8: With `m_ready` held high and `wm_valid` high, `s_ready` stays high and one coefficient is accepted every cycle.
- R9: The key uses taps 16,14,13,11. Each step shifts left and puts the XOR of state bits 15,13,12,10 into bit 0. When `frame_start` is high, the key used in that cycle is `cfg_seed`, and a zero seed is replaced by 1. The key advances once per accepted DC coefficient and at no other time.
- R10: A computed plane above 14 is clamped to plane 14.
- R11: `wm_ready` is high only while a DC coefficient is offered in embed mode. A watermark bit is consumed only together with that coefficient.
- R12: Raising `frame_start` with the same seed in the middle of a stream restarts the key sequence from its first value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_extract | input | 1 | 0 = embed, 1 = extract |
| cfg_span | input | 2 | Plane window width code |
| cfg_base | input | 4 | Lowest plane of the window |
| cfg_seed | input | 16 | Key seed |
| frame_start | input | 1 | Use seed as the key for this cycle and restart the sequence |
| s_valid | input | 1 | Coefficient offered |
| s_ready | output | 1 | Coefficient accepted this cycle when valid |
| s_coef | input | 16 | Two's complement coefficient |
| s_is_dc | input | 1 | Coefficient belongs to the DC subband |
| wm_valid | input | 1 | Watermark bit offered |
| wm_ready | output | 1 | Watermark bit consumed this cycle when valid |
| wm_bit | input | 1 | Watermark bit |
| m_valid | output | 1 | Result valid |
| m_ready | input | 1 | Downstream accepts the result |
| m_coef | output | 16 | Outgoing coefficient |
| m_is_dc | output | 1 | DC flag of the outgoing coefficient |
| m_xbit | output | 1 | Embedded or extracted bit, 0 for non-DC |

## Verification
A key that is wrong by one step, or that advances on non-DC traffic, moves the chosen plane. The error shows on the next DC coefficient whose window offset changes. With a four-plane window that usually happens within a few coefficients, and it appears as a wrong bit in `m_coef` or `m_xbit`. A wrong handshake term shows in the same cycle, either as lost or repeated results during stalls or as watermark bits taken on non-DC beats. Each of these breaks the one-to-one order between sent and received items.

// File: rtl/wm_pkg.sv
package wm_pkg;
  typedef enum logic [1:0] {
    SPAN_ONE  = 2'd0,
    SPAN_TWO  = 2'd1,
    SPAN_FOUR = 2'd2,
    SPAN_WIDE = 2'd3
  } wm_span_e;

  function automatic int unsigned span_mask(input wm_span_e s);
    case (s)
      SPAN_ONE: return 0;
      SPAN_TWO: return 1;
      default:  return 3;
    endcase
  endfunction
endpackage

// File: rtl/wm_key_lfsr.sv
module wm_key_lfsr #(
  parameter int unsigned W        = 16,
  parameter logic [15:0] TAP_MASK = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         step,
  output logic [W-1:0] key
);
  logic [W-1:0] state_q;
  logic [W-1:0] seed_nz;
  logic [W-1:0] key_next;
  logic [W-1:0] taps;

  assign taps     = W'(TAP_MASK);
  assign seed_nz  = (seed == '0) ? W'(1) : seed;
  assign key      = load ? seed_nz : state_q;
  assign key_next = {key[W-2:0], ^(key & taps)};

  always_ff @(posedge clk) begin
    if (!rst_n)    state_q <= W'(1);
    else if (step) state_q <= key_next;
    else if (load) state_q <= seed_nz;
  end
endmodule

// File: rtl/wm_plane_sel.sv
module wm_plane_sel
  import wm_pkg::*;
#(
  parameter int unsigned COEF_W  = 16,
  parameter int unsigned LFSR_W  = 16,
  parameter int unsigned PLANE_W = $clog2(COEF_W)
) (
  input  logic [LFSR_W-1:0]  key,
  input  wm_span_e           span,
  input  logic [PLANE_W-1:0] base,
  output logic [PLANE_W-1:0] plane
);
  localparam int unsigned TOP_PLANE = COEF_W - 2;

  logic [PLANE_W:0] sum;
  logic [1:0]       offset;

  always_comb begin
    offset = key[1:0] & 2'(span_mask(span));
    sum    = {1'b0, base} + (PLANE_W+1)'(offset);
    if (sum > (PLANE_W+1)'(TOP_PLANE)) plane = PLANE_W'(TOP_PLANE);
    else                               plane = sum[PLANE_W-1:0];
  end
endmodule

// File: rtl/wm_bit_mux.sv
module wm_bit_mux #(
  parameter int unsigned COEF_W  = 16,
  parameter int unsigned PLANE_W = $clog2(COEF_W)
) (
  input  logic [COEF_W-1:0]  coef_in,
  input  logic               is_dc,
  input  logic               extract,
  input  logic [PLANE_W-1:0] plane,
  input  logic               mark,
  output logic [COEF_W-1:0]  coef_out,
  output logic               xbit
);
  logic do_embed;
  assign do_embed = is_dc && !extract;

  for (genvar i = 0; i < COEF_W; i++) begin : g_bit
    if (i == COEF_W - 1) begin : g_sign
      assign coef_out[i] = coef_in[i];
    end else begin : g_mag
      assign coef_out[i] = (do_embed && plane == PLANE_W'(i)) ? mark : coef_in[i];
    end
  end

  always_comb begin
    if (!is_dc)       xbit = 1'b0;
    else if (extract) xbit = coef_in[plane];
    else              xbit = mark;
  end
endmodule

// File: rtl/wm_bitplane_embed.sv
module wm_bitplane_embed
  import wm_pkg::*;
#(
  parameter int unsigned COEF_W   = 16,
  parameter int unsigned LFSR_W   = 16,
  parameter logic [15:0] TAP_MASK = 16'hB400
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_extract,
  input  logic [1:0]                 cfg_span,
  input  logic [$clog2(COEF_W)-1:0]  cfg_base,
  input  logic [LFSR_W-1:0]          cfg_seed,
  input  logic                       frame_start,
  input  logic                       s_valid,
  output logic                       s_ready,
  input  logic [COEF_W-1:0]          s_coef,
  input  logic                       s_is_dc,
  input  logic                       wm_valid,
  output logic                       wm_ready,
  input  logic                       wm_bit,
  output logic                       m_valid,
  input  logic                       m_ready,
  output logic [COEF_W-1:0]          m_coef,
  output logic                       m_is_dc,
  output logic                       m_xbit
);
  localparam int unsigned PLANE_W = $clog2(COEF_W);

  logic               out_free;
  logic               need_mark;
  logic               fire;
  logic               dc_fire;
  logic [LFSR_W-1:0]  key;
  logic [PLANE_W-1:0] plane;
  logic [COEF_W-1:0]  mux_coef;
  logic               mux_xbit;

  assign out_free  = !m_valid || m_ready;
  assign need_mark = s_is_dc && !cfg_extract;
  assign s_ready   = out_free && (!need_mark || wm_valid);
  assign wm_ready  = out_free && s_valid && need_mark;
  assign fire      = s_valid && s_ready;
  assign dc_fire   = fire && s_is_dc;

  wm_key_lfsr #(.W(LFSR_W), .TAP_MASK(TAP_MASK)) u_key (
    .clk  (clk),
    .rst_n(rst_n),
    .load (frame_start),
    .seed (cfg_seed),
    .step (dc_fire),
    .key  (key)
  );

  wm_plane_sel #(.COEF_W(COEF_W), .LFSR_W(LFSR_W), .PLANE_W(PLANE_W)) u_sel (
    .key  (key),
    .span (wm_span_e'(cfg_span)),
    .base (cfg_base),
    .plane(plane)
  );

  wm_bit_mux #(.COEF_W(COEF_W), .PLANE_W(PLANE_W)) u_mux (
    .coef_in (s_coef),
    .is_dc   (s_is_dc),
    .extract (cfg_extract),
    .plane   (plane),
    .mark    (wm_bit),
    .coef_out(mux_coef),
    .xbit    (mux_xbit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_coef  <= '0;
      m_is_dc <= 1'b0;
      m_xbit  <= 1'b0;
    end else if (fire) begin
      m_valid <= 1'b1;
      m_coef  <= mux_coef;
      m_is_dc <= s_is_dc;
      m_xbit  <= mux_xbit;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/wm_embed_chk.sv
module wm_embed_chk #(
  parameter int unsigned COEF_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_extract,
  input logic              s_valid,
  input logic              s_ready,
  input logic [COEF_W-1:0] s_coef,
  input logic              s_is_dc,
  input logic              wm_valid,
  input logic              wm_ready,
  input logic              m_valid,
  input logic              m_ready,
  input logic [COEF_W-1:0] m_coef,
  input logic              m_is_dc,
  input logic              m_xbit
);
  logic acc;
  assign acc = s_valid && s_ready;

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !m_valid); // R1

  AST_NONDC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !s_is_dc |=> m_valid && !m_is_dc && !m_xbit && m_coef == $past(s_coef)); // R2

  AST_ONE_BIT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    acc && s_is_dc && !cfg_extract |=> $countones(m_coef ^ $past(s_coef)) <= 1); // R3

  AST_SIGN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    acc && s_is_dc |=> m_coef[COEF_W-1] == $past(s_coef[COEF_W-1])); // R5

  AST_EXTRACT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cfg_extract |=> m_coef == $past(s_coef)); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_coef) && $stable(m_is_dc) && $stable(m_xbit)); // R7

  AST_MARK_WITH_COEF: assert property (@(posedge clk) disable iff (!rst_n)
    wm_valid && wm_ready |-> acc && s_is_dc && !cfg_extract); // R11
endmodule

bind wm_bitplane_embed wm_embed_chk #(.COEF_W(COEF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_extract(cfg_extract),
  .s_valid(s_valid), .s_ready(s_ready), .s_coef(s_coef), .s_is_dc(s_is_dc),
  .wm_valid(wm_valid), .wm_ready(wm_ready),
  .m_valid(m_valid), .m_ready(m_ready), .m_coef(m_coef),
  .m_is_dc(m_is_dc), .m_xbit(m_xbit)
);

// File: tb/wm_bitplane_embed_tb_top.sv
module wm_bitplane_embed_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_extract = 1'b0;
  logic [1:0]  cfg_span = 2'd0;
  logic [3:0]  cfg_base = 4'd0;
  logic [15:0] cfg_seed = 16'h0001;
  logic        frame_start = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_coef = '0;
  logic        s_is_dc = 1'b0;
  logic        wm_valid = 1'b0;
  logic        wm_ready;
  logic        wm_bit = 1'b0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [15:0] m_coef;
  logic        m_is_dc;
  logic        m_xbit;

  always #10 clk = ~clk;

  wm_bitplane_embed dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_extract(cfg_extract), .cfg_span(cfg_span),
    .cfg_base(cfg_base), .cfg_seed(cfg_seed), .frame_start(frame_start),
    .s_valid(s_valid), .s_ready(s_ready), .s_coef(s_coef), .s_is_dc(s_is_dc),
    .wm_valid(wm_valid), .wm_ready(wm_ready), .wm_bit(wm_bit),
    .m_valid(m_valid), .m_ready(m_ready), .m_coef(m_coef),
    .m_is_dc(m_is_dc), .m_xbit(m_xbit)
  );

  typedef struct {
    logic [15:0] coef;
    logic        dc;
    logic        xbit;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          n_tests = 0;
  int          n_fail = 0;
  logic [15:0] tb_key = 16'h0001;
  logic [31:0] rng = 32'h1234_5678;
  bit          bp_on = 1'b0;
  bit          burst = 1'b0;
  int          cyc = 0;

  function automatic logic [15:0] key_step(input logic [15:0] k);
    return {k[14:0], k[15] ^ k[13] ^ k[12] ^ k[10]};
  endfunction

  function automatic logic [15:0] next_rand();
    rng = rng * 32'd1103515245 + 32'd12345;
    return rng[31:16];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R4 R9 R10 R12: bench model of key, window and clamp
  task automatic send(input logic [15:0] coef, input bit dc, input bit mark, input bit fs, input string tag);
    exp_t        e;
    logic [15:0] cur;
    int          mask;
    int          plane;
    @(negedge clk);
    s_valid = 1'b1; s_coef = coef; s_is_dc = dc;
    wm_valid = 1'b1; wm_bit = mark; frame_start = fs;
    #2;
    if (burst) check(s_ready == 1'b1, "R8 s_ready in burst", 32'(s_ready), 32'd1);
    if (!dc) check(wm_ready == 1'b0, "R11 wm_ready on non-DC", 32'(wm_ready), 32'd0);
    if (dc && cfg_extract) check(wm_ready == 1'b0, "R11 wm_ready in extract", 32'(wm_ready), 32'd0);
    while (!s_ready) begin
      @(negedge clk); #2;
    end
    cur  = fs ? ((cfg_seed == 16'h0) ? 16'h0001 : cfg_seed) : tb_key;
    mask = (cfg_span == 2'd0) ? 0 : (cfg_span == 2'd1) ? 1 : 3;
    plane = int'(cfg_base) + (int'(cur[1:0]) & mask);
    if (plane > 14) plane = 14;
    e.coef = coef; e.dc = dc; e.xbit = 1'b0; e.tag = tag;
    if (dc) begin
      if (cfg_extract) e.xbit = coef[plane];
      else begin
        e.coef[plane] = mark;
        e.xbit = mark;
      end
      tb_key = key_step(cur);
    end else if (fs) begin
      tb_key = cur;
    end
    sb_q.push_back(e);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    s_valid = 1'b0; wm_valid = 1'b0; frame_start = 1'b0;
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while (sb_q.size() != 0 && guard < 200) begin
      @(negedge clk); guard++;
    end
    check(sb_q.size() == 0, "scoreboard drained", 32'(sb_q.size()), 32'd0);
  endtask

  // monitor: decides m_ready, then compares any beat leaving at the next edge
  always @(negedge clk) begin
    cyc++;
    m_ready = bp_on ? ((cyc % 3) != 0) : 1'b1;
    #1;
    if (rst_n && m_valid && m_ready) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "unexpected output beat", 32'(m_coef), 32'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(m_coef == e.coef, {e.tag, " coef"}, 32'(m_coef), 32'(e.coef));
        check(m_is_dc == e.dc && m_xbit == e.xbit, {e.tag, " dc/xbit"},
              {30'd0, m_is_dc, m_xbit}, {30'd0, e.dc, e.xbit});
      end
    end
  end

  // R7: while stalled, output must hold
  logic [15:0] held_coef;
  bit          held;
  always @(posedge clk) begin
    if (held && rst_n) check(m_valid && m_coef == held_coef, "R7 stall hold", 32'(m_coef), 32'(held_coef));
    held      = rst_n && m_valid && !m_ready;
    held_coef = m_coef;
  end

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'd0, 32'd1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    check(m_valid == 1'b0, "R1 m_valid in reset", 32'(m_valid), 32'd0);
    rst_n = 1'b1;
    #1;
    check(m_valid == 1'b0, "R1 m_valid after reset", 32'(m_valid), 32'd0);

    // R2 R3 R5 R11: single plane, mixed traffic, negative values
    cfg_extract = 1'b0; cfg_span = 2'd0; cfg_base = 4'd3; cfg_seed = 16'hACE1;
    for (int i = 0; i < 16; i++) begin
      logic [15:0] c;
      c = next_rand();
      if (i % 3 == 0) c[15] = 1'b1;
      send(c, (i % 2) == 0, c[3] ^ 1'b1, i == 0, (i % 2) == 0 ? "R3 R5 embed one plane" : "R2 non-DC pass");
    end
    idle(); drain();

    // R4 R8: four-plane window, back-to-back burst
    cfg_span = 2'd2; cfg_base = 4'd2; burst = 1'b1;
    for (int i = 0; i < 20; i++) begin
      logic [15:0] c;
      c = next_rand();
      send(c, 1'b1, c[0], i == 0, "R4 R8 four planes burst");
    end
    burst = 1'b0;
    idle(); drain();

    // R4 R7: two-plane window with back-pressure
    cfg_span = 2'd1; cfg_base = 4'd0; bp_on = 1'b1;
    for (int i = 0; i < 20; i++) begin
      logic [15:0] c;
      c = next_rand();
      send(c, (i % 4) != 3, ~c[1], i == 0, "R4 R7 two planes stalled");
    end
    idle(); drain();
    bp_on = 1'b0;

    // R6: extract mode, unchanged coefficients, bit read back
    cfg_extract = 1'b1; cfg_span = 2'd3; cfg_base = 4'd5; cfg_seed = 16'h5A5A;
    for (int i = 0; i < 20; i++) begin
      logic [15:0] c;
      c = next_rand();
      send(c, (i % 5) != 2, 1'b1, i == 0, "R6 extract");
    end
    idle(); drain();

    // R9: zero seed treated as one
    cfg_extract = 1'b0; cfg_span = 2'd2; cfg_base = 4'd0; cfg_seed = 16'h0000;
    for (int i = 0; i < 12; i++) begin
      send(16'h0000, 1'b1, 1'b1, i == 0, "R9 zero seed");
    end
    idle(); drain();

    // R10: window running past the top magnitude bit
    cfg_span = 2'd2; cfg_base = 4'd13; cfg_seed = 16'hBEEF;
    for (int i = 0; i < 12; i++) begin
      send(16'h0000, 1'b1, 1'b1, i == 0, "R10 clamp to plane 14");
    end
    idle(); drain();

    // R12: restart mid-stream with the same seed
    cfg_span = 2'd2; cfg_base = 4'd4; cfg_seed = 16'h1357;
    for (int i = 0; i < 14; i++) begin
      logic [15:0] c;
      c = next_rand();
      send(c, 1'b1, c[2] ^ 1'b1, (i == 0) || (i == 7), "R12 frame restart");
    end
    idle(); drain();

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule